// File: doc/BRIEF.md
# Single-Precision Classify and Compare Unit

This unit takes two binary32 floating-point operands and a three-bit operation code. It returns one of six answers: a one-hot classification mask for the first operand, an equality test, a strict or non-strict ordered comparison, or the minimum or the maximum of the pair. Each answer comes with a five-bit exception vector. The only exception this unit can raise is invalid-operation. All arithmetic flags stay clear.

An operation is accepted on any clock cycle where `in_valid` is high. Its result and flags are registered and appear on the next cycle, qualified by `out_valid`. When no operation is presented, the output registers keep their last value. A pipeline can therefore issue one operation per cycle.

The subtle part of the unit is NaN and zero handling. Quiet and signalling NaNs behave differently in equality, in the ordered compares and in min/max. Signed zeros compare equal in every test, but min/max orders negative zero below positive zero.

Top module: `fpcc_unit`

## Requirements
- R1: When `in_valid` is high, `out_valid` is high on the next cycle and `result`/`flags` carry that operation's answer. When `in_valid` is low, `out_valid` is low on the next cycle and `result`/`flags` keep their previous values, whatever `op`, `opnd_a` and `opnd_b` hold.
- R2: While `rst` is high on a clock edge, `out_valid`, `result` and `flags` are cleared to zero.
- R3: Classify (op 0) returns a one-hot mask of `opnd_a` in `result[9:0]`, with `result[31:10]` zero. The bit meanings are: bit 0 negative infinity, bit 1 negative normal, bit 2 negative subnormal, bit 3 negative zero, bit 4 positive zero, bit 5 positive subnormal, bit 6 positive normal, bit 7 positive infinity, bit 8 signalling NaN, bit 9 quiet NaN. Classify never raises invalid.
- R4: A NaN (all-ones exponent, non-zero mantissa) is quiet when mantissa bit 22 is 1 and signalling when it is 0. For example, 0x7f800001 is signalling and 0x7fc00000 is quiet.
- R5: Equality (op 1) returns 0 whenever either operand is a NaN. It raises invalid only when at least one operand is a signalling NaN. Negative zero equals positive zero.
- R6: Less-than (op 2) and less-or-equal (op 3) return 0 and raise invalid whenever either operand is any kind of NaN.
- R7: For non-NaN operands, equality and the ordered compares follow numeric value. Two infinities of the same sign, or any two zeros, give equal=1, less-or-equal=1 and less-than=0.
- R8: Min (op 4) and max (op 5) with exactly one NaN operand return the other operand unchanged. They raise invalid only if that NaN is signalling.
- R9: Min and max with both operands NaN return the canonical NaN 0x7fc00000. They raise invalid only if at least one of the two is signalling.
- R10: Min and max rank negative zero below positive zero, in either operand order. Min of the two zeros returns 0x80000000 and max returns 0x00000000.
- R11: In `flags`, bit 4 is invalid-operation and bits 3..0 are always 0. Compare results are 0 or 1 in `result[0]`, with `result[31:1]` zero.
- R12: Operation codes 6 and 7 are unused. They return `result` 0 and `flags` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code: 0 classify, 1 equal, 2 less-than, 3 less-or-equal, 4 min, 5 max |
| opnd_a | input | 32 | First binary32 operand |
| opnd_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result registers updated by the previous cycle's operation |
| result | output | 32 | Mask, boolean or selected value |
| flags | output | 5 | Exception vector, bit 4 invalid |

## Verification
On every cycle, the assertions check the following:
- the one-cycle valid timing and the output hold;
- that the classify mask is one-hot;
- that compare results are confined to bit 0;
- that the four non-invalid flag bits stay clear;
- that a NaN into an ordered compare yields 0 with invalid;
- that a pair of NaNs into min/max yields the canonical NaN;
- that spare operation codes produce zeros.

Other behaviours can only be shown by the bench's scenarios, which compare each result against a behavioural model:
- which of the two operands min/max picks;
- how signed zeros rank;
- the difference between quiet and signalling NaNs in equality;
- correct numeric ordering across signs and magnitudes.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int SP_EXP_W  = 8;
    localparam int SP_MAN_W  = 23;
    localparam int CLASS_W   = 10;
    localparam int FLAG_W    = 5;
    localparam int FLAG_NV   = 4;
    localparam int OPC_W     = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_CLASS = 3'd0,
        OP_EQ    = 3'd1,
        OP_LT    = 3'd2,
        OP_LE    = 3'd3,
        OP_MIN   = 3'd4,
        OP_MAX   = 3'd5
    } fpcc_op_e;

    // Decoded category of one operand
    typedef struct packed {
        logic sign;
        logic is_inf;
        logic is_zero;
        logic is_sub;
        logic is_norm;
        logic is_snan;
        logic is_qnan;
    } fp_info_t;

    typedef struct packed {
        logic [SP_EXP_W+SP_MAN_W:0] value;
        logic [FLAG_W-1:0]          flags;
    } fpcc_resp_t;

    // Ten-way category mask, lowest bit = negative infinity
    function automatic logic [CLASS_W-1:0] class_mask(input fp_info_t i);
        logic [CLASS_W-1:0] m;
        m[0] = i.sign  & i.is_inf;
        m[1] = i.sign  & i.is_norm;
        m[2] = i.sign  & i.is_sub;
        m[3] = i.sign  & i.is_zero;
        m[4] = ~i.sign & i.is_zero;
        m[5] = ~i.sign & i.is_sub;
        m[6] = ~i.sign & i.is_norm;
        m[7] = ~i.sign & i.is_inf;
        m[8] = i.is_snan;
        m[9] = i.is_qnan;
        return m;
    endfunction

endpackage

// File: rtl/fpcc_decode.sv
module fpcc_decode
    import fpcc_pkg::*;
#(
    parameter int EXP_W = SP_EXP_W,
    parameter int MAN_W = SP_MAN_W,
    localparam int FP_W = EXP_W + MAN_W + 1
) (
    input  logic [FP_W-1:0] x,
    output fp_info_t        info
);
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;
    logic exp_ones, exp_zero, man_zero, nan;

    always_comb begin
        expo     = x[FP_W-2 -: EXP_W];
        mant     = x[MAN_W-1:0];
        exp_ones = &expo;
        exp_zero = ~|expo;
        man_zero = ~|mant;
        nan      = exp_ones & ~man_zero;

        info.sign    = x[FP_W-1];
        info.is_inf  = exp_ones & man_zero;
        info.is_zero = exp_zero & man_zero;
        info.is_sub  = exp_zero & ~man_zero;
        info.is_norm = ~exp_ones & ~exp_zero;
        // top mantissa bit separates quiet from signalling
        info.is_qnan = nan & mant[MAN_W-1];
        info.is_snan = nan & ~mant[MAN_W-1];
    end
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order #(
    parameter int FP_W = 32
) (
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    input  logic            zero_a,
    input  logic            zero_b,
    output logic            num_eq,
    output logic            num_lt,
    output logic            tot_lt
);
    localparam int MAG_W = FP_W - 1;

    logic [MAG_W-1:0] mag_a, mag_b;
    logic mag_lt, mag_eq, both_zero, sa, sb;

    always_comb begin
        sa        = a[FP_W-1];
        sb        = b[FP_W-1];
        mag_a     = a[MAG_W-1:0];
        mag_b     = b[MAG_W-1:0];
        mag_lt    = mag_a < mag_b;
        mag_eq    = mag_a == mag_b;
        both_zero = zero_a & zero_b;

        // total order with -0 below +0, NaNs excluded by caller
        if (sa != sb)
            tot_lt = sa;
        else if (!sa)
            tot_lt = mag_lt;
        else
            tot_lt = ~mag_lt & ~mag_eq;

        num_lt = tot_lt & ~both_zero;
        num_eq = (mag_eq & (sa == sb)) | both_zero;
    end
endmodule

// File: rtl/fpcc_minmax.sv
module fpcc_minmax #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int FP_W = EXP_W + MAN_W + 1
) (
    input  logic [FP_W-1:0] a,
    input  logic [FP_W-1:0] b,
    input  logic            nan_a,
    input  logic            nan_b,
    input  logic            snan_a,
    input  logic            snan_b,
    input  logic            tot_lt,
    input  logic            sel_max,
    output logic [FP_W-1:0] value,
    output logic            invalid
);
    localparam logic [FP_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic pick_a;

    always_comb begin
        pick_a  = sel_max ? ~tot_lt : tot_lt;
        invalid = snan_a | snan_b;
        if (nan_a && nan_b)
            value = CANON_NAN;
        else if (nan_a)
            value = b;
        else if (nan_b)
            value = a;
        else
            value = pick_a ? a : b;
    end
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
    import fpcc_pkg::*;
#(
    parameter int EXP_W = SP_EXP_W,
    parameter int MAN_W = SP_MAN_W,
    localparam int FP_W = EXP_W + MAN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OPC_W-1:0] op,
    input  logic [FP_W-1:0]  opnd_a,
    input  logic [FP_W-1:0]  opnd_b,
    output logic             out_valid,
    output logic [FP_W-1:0]  result,
    output logic [FLAG_W-1:0] flags
);
    localparam int N_OPND = 2;
    localparam logic [FP_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [N_OPND-1:0][FP_W-1:0] opnd;
    fp_info_t info [N_OPND];
    logic [N_OPND-1:0] nan_v, snan_v;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    for (genvar i = 0; i < N_OPND; i++) begin : g_dec
        fpcc_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
            .x    (opnd[i]),
            .info (info[i])
        );
        assign nan_v[i]  = info[i].is_snan | info[i].is_qnan;
        assign snan_v[i] = info[i].is_snan;
    end

    logic num_eq, num_lt, tot_lt;

    fpcc_order #(.FP_W(FP_W)) u_order (
        .a      (opnd_a),
        .b      (opnd_b),
        .zero_a (info[0].is_zero),
        .zero_b (info[1].is_zero),
        .num_eq (num_eq),
        .num_lt (num_lt),
        .tot_lt (tot_lt)
    );

    logic [FP_W-1:0] mm_value;
    logic            mm_invalid;

    fpcc_minmax #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_minmax (
        .a       (opnd_a),
        .b       (opnd_b),
        .nan_a   (nan_v[0]),
        .nan_b   (nan_v[1]),
        .snan_a  (snan_v[0]),
        .snan_b  (snan_v[1]),
        .tot_lt  (tot_lt),
        .sel_max (op == OP_MAX),
        .value   (mm_value),
        .invalid (mm_invalid)
    );

    fpcc_resp_t nxt;
    logic any_nan, any_snan;

    always_comb begin
        any_nan  = |nan_v;
        any_snan = |snan_v;
        nxt      = '0;
        case (op)
            OP_CLASS: nxt.value = FP_W'(class_mask(info[0]));
            OP_EQ: begin
                nxt.value[0]        = num_eq & ~any_nan;
                nxt.flags[FLAG_NV]  = any_snan;
            end
            OP_LT: begin
                nxt.value[0]        = num_lt & ~any_nan;
                nxt.flags[FLAG_NV]  = any_nan;
            end
            OP_LE: begin
                nxt.value[0]        = (num_lt | num_eq) & ~any_nan;
                nxt.flags[FLAG_NV]  = any_nan;
            end
            OP_MIN, OP_MAX: begin
                nxt.value           = mm_value;
                nxt.flags[FLAG_NV]  = mm_invalid;
            end
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt.value;
                flags  <= nxt.flags;
            end
        end
    end

    // ---------------- assertions ----------------
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(flags)));
    p_spare_flags_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags[FLAG_NV-1:0] == '0));
    p_class_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == OP_CLASS) |->
            ($onehot(result[CLASS_W-1:0]) && result[FP_W-1:CLASS_W] == '0
             && !flags[FLAG_NV]));
    p_cmp_bool_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(op) == OP_EQ || $past(op) == OP_LT || $past(op) == OP_LE))
            |-> (result[FP_W-1:1] == '0));
    p_ord_nan_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(op) == OP_LT || $past(op) == OP_LE) && $past(|nan_v))
            |-> (result == '0 && flags[FLAG_NV]));
    p_both_nan_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(op) == OP_MIN || $past(op) == OP_MAX) && $past(&nan_v))
            |-> (result == CANON_NAN));
    p_spare_op_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) > OP_MAX) |-> (result == '0 && flags == '0));

endmodule

// File: tb/fpcc_unit_tb.sv
module fpcc_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [31:0] opnd_a, opnd_b;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpcc_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .result(result), .flags(flags)
    );

    // ---------- behavioural reference ----------
    function automatic bit m_nan(input logic [31:0] x);
        return (x[30:23] == 8'hff) && (x[22:0] != 0);
    endfunction
    function automatic bit m_snan(input logic [31:0] x);
        return m_nan(x) && !x[22];
    endfunction
    // signed ordering key: zeros of both signs map to 0
    function automatic longint m_key(input logic [31:0] x);
        longint mag = longint'(x[30:0]);
        return x[31] ? -mag : mag;
    endfunction
    function automatic int m_class(input logic [31:0] x);
        if (m_nan(x)) return m_snan(x) ? 8 : 9;
        if (x[30:23] == 8'hff) return x[31] ? 0 : 7;
        if (x[30:0] == 0) return x[31] ? 3 : 4;
        if (x[30:23] == 0) return x[31] ? 2 : 5;
        return x[31] ? 1 : 6;
    endfunction

    // returns {result, flags}
    function automatic logic [36:0] model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
        bit nx = m_nan(x), ny = m_nan(y);
        bit sn = m_snan(x) || m_snan(y);
        longint kx = m_key(x), ky = m_key(y);
        logic [31:0] r = 0;
        logic [4:0]  f = 0;
        case (o)
            3'd0: r = 32'd1 << m_class(x);
            3'd1: begin r = (!nx && !ny && kx == ky) ? 1 : 0; f = sn ? 5'h10 : 0; end
            3'd2: begin r = (!nx && !ny && kx <  ky) ? 1 : 0; f = (nx || ny) ? 5'h10 : 0; end
            3'd3: begin r = (!nx && !ny && kx <= ky) ? 1 : 0; f = (nx || ny) ? 5'h10 : 0; end
            3'd4, 3'd5: begin
                f = sn ? 5'h10 : 0;
                if (nx && ny) r = 32'h7fc00000;
                else if (nx) r = y;
                else if (ny) r = x;
                else if (kx < ky) r = (o == 3'd4) ? x : y;
                else if (ky < kx) r = (o == 3'd4) ? y : x;
                else if (o == 3'd4) r = x[31] ? x : y;
                else r = x[31] ? y : x;
            end
            default: begin r = 0; f = 0; end
        endcase
        return {r, f};
    endfunction

    logic [31:0] last_r;
    logic [4:0]  last_f;

    task automatic check(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual result=%h flags=%h, expected result=%h flags=%h",
                     tag, act[36:5], act[4:0], exp[36:5], exp[4:0]);
        end
    endtask

    // one operation, checked on the following cycle
    task automatic run(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y, input string tag);
        logic [36:0] e = model(o, x, y);
        op = o; opnd_a = x; opnd_b = y; in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && result == e[36:5] && flags == e[4:0], tag, {result, flags}, e);
        last_r = result; last_f = flags;
    endtask

    task automatic idle(input string tag);
        in_valid = 1'b0; op = 3'($urandom); opnd_a = $urandom; opnd_b = $urandom;
        @(posedge clk); @(negedge clk);
        check(!out_valid && result == last_r && flags == last_f, tag,
              {result, flags}, {last_r, last_f});
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 11))
            0: return 32'h00000000;
            1: return 32'h80000000;
            2: return 32'h7f800000;
            3: return 32'hff800000;
            4: return 32'h7fc00000;
            5: return 32'h7f800001;
            6: return 32'hffa00000;
            7: return {$urandom_range(0, 1) == 1, 8'h00, 23'($urandom)};
            8: return 32'h3f800000;
            9: return 32'hbf800000;
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = 0; opnd_a = 0; opnd_b = 0;
        last_r = 0; last_f = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 reset state
        check(!out_valid && result == 0 && flags == 0, "R2 reset", {result, flags}, 37'd0);
        rst = 1'b0;

        // R3 classify of each non-NaN category
        run(0, 32'hff800000, 0, "R3 -inf");
        run(0, 32'hbf800000, 0, "R3 -normal");
        run(0, 32'h807fffff, 0, "R3 -subnormal");
        run(0, 32'h80000000, 0, "R3 -zero");
        run(0, 32'h00000000, 0, "R3 +zero");
        run(0, 32'h007fffff, 0, "R3 +subnormal");
        run(0, 32'h3f800000, 0, "R3 +normal");
        run(0, 32'h7f800000, 0, "R3 +inf");
        // R4 quiet vs signalling
        run(0, 32'h7f800001, 0, "R4 snan");
        run(0, 32'h7fc00000, 0, "R4 qnan");
        run(0, 32'hffffffff, 0, "R4 negative qnan");
        run(0, 32'hffbfffff, 0, "R4 negative snan");
        // R5 equality
        run(1, 32'h7fc00000, 32'h00000000, "R5 eq qnan");
        run(1, 32'h7fc00000, 32'h7fc00000, "R5 eq qnan qnan");
        run(1, 32'h7f800001, 32'h00000000, "R5 eq snan");
        run(1, 32'h80000000, 32'h00000000, "R5 eq -0 +0");
        // R6 ordered compares with NaN
        run(2, 32'h7fc00000, 32'h00000000, "R6 lt qnan");
        run(2, 32'h7f800001, 32'h00000000, "R6 lt snan");
        run(3, 32'h7fc00000, 32'h7fc00000, "R6 le qnan qnan");
        run(3, 32'h00000000, 32'h7f800001, "R6 le snan");
        // R7 numeric ordering
        run(1, 32'hff800000, 32'hff800000, "R7 eq -inf");
        run(3, 32'hff800000, 32'hff800000, "R7 le -inf");
        run(2, 32'hff800000, 32'hff800000, "R7 lt -inf");
        run(3, 32'h00000000, 32'h80000000, "R7 le zeros");
        run(2, 32'h80000000, 32'h00000000, "R7 lt zeros");
        run(2, 32'hbfaf5c29, 32'hbfae147b, "R7 lt negatives");
        run(3, 32'hbfae147b, 32'hbfaf5c29, "R7 le negatives");
        run(2, 32'hc49a6333, 32'h3f8ccccd, "R7 lt mixed sign");
        // R8 one NaN in min/max
        run(4, 32'h7fc00000, 32'hc49a6333, "R8 min qnan");
        run(5, 32'h3f800000, 32'h7fc00000, "R8 max qnan");
        run(5, 32'h7f800001, 32'h3f800000, "R8 max snan");
        // R9 both NaN
        run(5, 32'hffffffff, 32'h7fc00001, "R9 max qnan qnan");
        run(4, 32'h7f800001, 32'h7fc00000, "R9 min snan qnan");
        // R10 signed zeros
        run(4, 32'h80000000, 32'h00000000, "R10 min -0 +0");
        run(4, 32'h00000000, 32'h80000000, "R10 min +0 -0");
        run(5, 32'h80000000, 32'h00000000, "R10 max -0 +0");
        run(5, 32'h00000000, 32'h80000000, "R10 max +0 -0");
        // R12 spare codes
        run(6, 32'h3f800000, 32'h7f800001, "R12 op6");
        run(7, 32'h7f800001, 32'h7f800001, "R12 op7");
        // R1 hold when idle
        run(5, 32'h7f800001, 32'h3f800000, "R1 setup");
        idle("R1 hold");
        idle("R1 hold again");
        // R11 random mixed operations, back to back
        for (int i = 0; i < 400; i++) begin
            run(3'($urandom_range(0, 7)), pick_val(), pick_val(), "R11 mixed");
            if (i % 37 == 0) idle("R1 idle gap");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule